// File: doc/BRIEF.md
# Locking Descriptor Pipe Arbiter

The block sits in front of a shared flash controller's register command port. A number of DMA descriptor pipes feed it: by default two hosts with three pipes each. It passes their descriptors on one at a time through a single output slot. Every descriptor carries a 6-bit flag field and a payload word. Flag bit 0 marks a command descriptor; with bit 0 clear it is a data descriptor. A host can claim the controller for an uninterrupted series of commands by setting the lock flag, and can give it back with the unlock flag. The notify-when-done flag holds a pipe back until the controller reports that the flagged descriptor has finished. The interrupt flag raises a per-pipe interrupt once the descriptor has been handed over.

Each pipe input is valid/ready. A pipe holds `in_valid_i` high, with its flags and payload unchanged, until it sees `in_ready_o` high at a clock edge. The block raises `in_ready_o` for at most one pipe per cycle, and only when the output slot is empty or is being emptied in that same cycle. The output is valid/ready as well. While `out_valid_o` is high and `out_ready_i` is low, the slot contents do not change. The completion input `done_i`/`done_pipe_i` is a plain one-cycle pulse that names the pipe whose blocking descriptor has finished.

Top module: `dpa_lock_arbiter`

## Requirements
- R1: After reset, `out_valid_o`, `irq_o` and `err_o` are all zero, and `in_ready_o` stays zero while no pipe is valid.
- R2: With no lock held, the block grants the first pipe after the most recently granted one, in cyclic index order, that is valid and not blocked. After reset the search begins at pipe 0. At most one `in_ready_o` bit is high, and only when the output slot is empty or is being drained in the same cycle.
- R3: A granted descriptor appears on the output slot in the cycle after its grant. It stays there, unchanged, until `out_ready_i` accepts it.
- R4: Granting a command descriptor that carries the lock flag (bit 3) pins arbitration to that pipe. From then on, only that pipe's command descriptors are granted.
- R5: A lock request from any other pipe waits and is not granted while the lock is held.
- R6: A command carrying the unlock flag (bit 4) blocks its pipe. The lock stays held until `done_i` names that pipe. Only after that can other pipes be granted.
- R7: A command carrying the notify-when-done flag (bit 2) blocks further grants to its pipe until `done_i` names that pipe. Other pipes keep being served.
- R8: If a descriptor with the interrupt flag (bit 1) is accepted at the output, `irq_o` for its pipe is high for exactly the next cycle. This holds for command and data descriptors alike.
- R9: On a data descriptor, the lock, unlock and notify-when-done flags have no effect. They are cleared on the output, and the pipe's `err_o` bit is set and stays set until reset.
- R10: The end-of-transfer flag (bit 5) passes through on data descriptors only. On a command descriptor it is cleared on the output and sets the pipe's `err_o` bit.
- R11: A `done_i` pulse naming a pipe that is not blocked changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | NP | Per-pipe descriptor valid |
| in_ready_o | output | NP | Per-pipe grant / accept |
| in_flags_i | input | NP*6 | Per-pipe flags: bit0 command, bit1 interrupt, bit2 notify-when-done, bit3 lock, bit4 unlock, bit5 end-of-transfer |
| in_data_i | input | NP*DATA_W | Per-pipe descriptor payload |
| out_valid_o | output | 1 | Output slot holds a descriptor |
| out_ready_i | input | 1 | Controller accepts the slot |
| out_pipe_o | output | IW | Source pipe of the slot |
| out_flags_o | output | 6 | Cleaned flags of the slot |
| out_data_o | output | DATA_W | Payload of the slot |
| done_i | input | 1 | Completion pulse |
| done_pipe_i | input | IW | Pipe named by the completion |
| irq_o | output | NP | Per-pipe interrupt pulse |
| err_o | output | NP | Per-pipe sticky flag-misuse error |

## Verification
The bench tries plain mixed traffic with the output always ready, which shows whether rotation order is correct. It then repeats the traffic with periodic output stalls, which shows whether grants respect slot occupancy and whether the slot holds steady. An overlapping lock scenario has three pipes trying to lock while a fourth sends data. This separates correct exclusion and release timing from early or late release. A final pattern feeds misused flags and spurious completions, to show that cleaning, sticky errors and ignored completions behave as required.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int FLAG_W = 6;
  localparam int F_CMD  = 0;
  localparam int F_INT  = 1;
  localparam int F_NWD  = 2;
  localparam int F_LOCK = 3;
  localparam int F_UNL  = 4;
  localparam int F_EOT  = 5;
endpackage

// File: rtl/dpa_flag_clean.sv
module dpa_flag_clean
  import dpa_pkg::*;
(
  input  logic [FLAG_W-1:0] raw_i,
  output logic [FLAG_W-1:0] clean_o,
  output logic              bad_o
);
  always_comb begin
    clean_o = raw_i;
    bad_o   = 1'b0;
    if (raw_i[F_CMD]) begin
      clean_o[F_EOT] = 1'b0;
      bad_o          = raw_i[F_EOT];
    end else begin
      clean_o[F_NWD]  = 1'b0;
      clean_o[F_LOCK] = 1'b0;
      clean_o[F_UNL]  = 1'b0;
      bad_o           = raw_i[F_NWD] | raw_i[F_LOCK] | raw_i[F_UNL];
    end
  end
endmodule

// File: rtl/dpa_rr_pick.sv
module dpa_rr_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_i) + k) % N;
      if (!vld_o && req_i[j]) begin
        vld_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/dpa_lock_arbiter.sv
module dpa_lock_arbiter
  import dpa_pkg::*;
#(
  parameter int HOSTS          = 2,
  parameter int PIPES_PER_HOST = 3,
  parameter int DATA_W         = 16,
  localparam int NP            = HOSTS * PIPES_PER_HOST,
  localparam int IW            = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP-1:0]        in_valid_i,
  output logic [NP-1:0]        in_ready_o,
  input  logic [NP*FLAG_W-1:0] in_flags_i,
  input  logic [NP*DATA_W-1:0] in_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [IW-1:0]        out_pipe_o,
  output logic [FLAG_W-1:0]    out_flags_o,
  output logic [DATA_W-1:0]    out_data_o,
  input  logic                 done_i,
  input  logic [IW-1:0]        done_pipe_i,
  output logic [NP-1:0]        irq_o,
  output logic [NP-1:0]        err_o
);
  logic [FLAG_W-1:0] cln [NP];
  logic [NP-1:0]     bad, elig;
  logic [NP-1:0]     wait_q, wait_d, err_q, err_d, irq_q;
  logic              lock_q, lock_d, unl_q, unl_d;
  logic [IW-1:0]     owner_q, owner_d, last_q, last_d;
  logic              outv_q, outv_d;
  logic [IW-1:0]     opipe_q, opipe_d;
  logic [FLAG_W-1:0] oflags_q, oflags_d;
  logic [DATA_W-1:0] odata_q, odata_d;
  logic              pick_vld, take, handoff, slot_free;
  logic [IW-1:0]     pick_idx;
  logic [FLAG_W-1:0] sel_flags;

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    dpa_flag_clean u_clean (
      .raw_i  (in_flags_i[p*FLAG_W +: FLAG_W]),
      .clean_o(cln[p]),
      .bad_o  (bad[p])
    );
    assign elig[p] = in_valid_i[p] & ~wait_q[p] &
                     (~lock_q | ((owner_q == IW'(p)) & cln[p][F_CMD]));
  end

  dpa_rr_pick #(.N(NP), .IW(IW)) u_pick (
    .req_i (elig),
    .last_i(last_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  assign handoff    = outv_q & out_ready_i;
  assign slot_free  = ~outv_q | out_ready_i;
  assign take       = slot_free & pick_vld;
  assign in_ready_o = take ? (NP'(1) << pick_idx) : '0;
  assign sel_flags  = cln[pick_idx];

  always_comb begin
    wait_d   = wait_q;
    lock_d   = lock_q;
    owner_d  = owner_q;
    unl_d    = unl_q;
    last_d   = last_q;
    err_d    = err_q;
    outv_d   = outv_q;
    opipe_d  = opipe_q;
    oflags_d = oflags_q;
    odata_d  = odata_q;
    if (done_i && (int'(done_pipe_i) < NP) && wait_q[done_pipe_i]) begin
      wait_d[done_pipe_i] = 1'b0;
      if (unl_q && (done_pipe_i == owner_q)) begin
        lock_d = 1'b0;
        unl_d  = 1'b0;
      end
    end
    if (take) begin
      outv_d   = 1'b1;
      opipe_d  = pick_idx;
      oflags_d = sel_flags;
      odata_d  = in_data_i[pick_idx*DATA_W +: DATA_W];
      last_d   = pick_idx;
      err_d[pick_idx] = err_q[pick_idx] | bad[pick_idx];
      if (sel_flags[F_LOCK] && !lock_q) begin
        lock_d  = 1'b1;
        owner_d = pick_idx;
      end
      if (sel_flags[F_NWD] || sel_flags[F_UNL]) wait_d[pick_idx] = 1'b1;
      if (sel_flags[F_UNL] && (lock_q || sel_flags[F_LOCK])) unl_d = 1'b1;
    end else if (handoff) begin
      outv_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wait_q   <= '0;
      lock_q   <= 1'b0;
      owner_q  <= '0;
      unl_q    <= 1'b0;
      last_q   <= IW'(NP - 1);
      err_q    <= '0;
      irq_q    <= '0;
      outv_q   <= 1'b0;
      opipe_q  <= '0;
      oflags_q <= '0;
      odata_q  <= '0;
    end else begin
      wait_q   <= wait_d;
      lock_q   <= lock_d;
      owner_q  <= owner_d;
      unl_q    <= unl_d;
      last_q   <= last_d;
      err_q    <= err_d;
      irq_q    <= (handoff && oflags_q[F_INT]) ? (NP'(1) << opipe_q) : '0;
      outv_q   <= outv_d;
      opipe_q  <= opipe_d;
      oflags_q <= oflags_d;
      odata_q  <= odata_d;
    end
  end

  assign out_valid_o = outv_q;
  assign out_pipe_o  = opipe_q;
  assign out_flags_o = oflags_q;
  assign out_data_o  = odata_q;
  assign irq_o       = irq_q;
  assign err_o       = err_q;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o) && (|in_ready_o -> |(in_ready_o & in_valid_i))); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_pipe_o))); // R3
  AST_LOCK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && |in_ready_o) |-> (in_ready_o == (NP'(1) << owner_q))); // R4
  AST_WAIT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o & wait_q) == '0); // R7
  AST_IRQ_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_o |-> $past(out_valid_o && out_ready_i)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o & $past(err_o)) == $past(err_o)); // R9
endmodule

// File: tb/dpa_lock_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpa_lock_arbiter_tb_top;
  localparam int NP = 6, DW = 16, IW = 3, FW = 6;
  localparam logic [5:0] C = 6'd1, I = 6'd2, N = 6'd4, L = 6'd8, U = 6'd16, E = 6'd32;
  typedef logic [DW+FW-1:0] desc_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni;
  logic [NP-1:0] in_valid, in_ready, irq, err;
  logic [NP*FW-1:0] in_flags;
  logic [NP*DW-1:0] in_data;
  logic out_valid, out_ready, done;
  logic [IW-1:0] out_pipe, done_pipe;
  logic [FW-1:0] out_flags;
  logic [DW-1:0] out_data;

  dpa_lock_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_flags_i(in_flags), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_pipe_o(out_pipe), .out_flags_o(out_flags),
    .out_data_o(out_data), .done_i(done), .done_pipe_i(done_pipe),
    .irq_o(irq), .err_o(err)
  );

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 0;
  bit spur_en = 0, spur = 0, timed_out = 0;
  desc_t pq [NP][$];
  int dq_pipe[$], dq_due[$];
  bit pop_pend [NP];
  int m_last, m_owner, m_opipe;
  bit m_lock, m_unl, m_outv;
  bit m_wait [NP];
  logic [5:0] m_oflags;
  logic [DW-1:0] m_odata;
  logic [NP-1:0] m_irq, m_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [5:0] clean(input logic [5:0] f, output bit b);
    logic [5:0] r;
    r = f;
    if (f[0]) begin b = f[5]; r[5] = 1'b0; end
    else begin b = |(f & (N | L | U)); r = f & ~(N | L | U); end
    return r;
  endfunction

  function automatic desc_t mk(input logic [5:0] f, input int d);
    return {DW'(d), f};
  endfunction

  task automatic step();
    int pick;
    bit slot, take, handoff, b;
    logic [5:0] raw, cf;
    logic [NP-1:0] exp_rdy;
    string tag;
    @(negedge clk);
    cyc++;
    for (int p = 0; p < NP; p++)
      if (pop_pend[p]) begin void'(pq[p].pop_front()); pop_pend[p] = 0; end
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = pq[p].size() > 0;
      in_flags[p*FW +: FW] = in_valid[p] ? pq[p][0][FW-1:0] : '0;
      in_data[p*DW +: DW]  = in_valid[p] ? pq[p][0][DW+FW-1:FW] : '0;
    end
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : (cyc % 5 < 2);
    done = 0; done_pipe = '0; spur = 0;
    if (dq_pipe.size() > 0 && dq_due[0] <= cyc) begin
      done = 1; done_pipe = IW'(dq_pipe[0]);
      void'(dq_pipe.pop_front()); void'(dq_due.pop_front());
    end else if (spur_en && cyc % 7 == 0) begin
      for (int p = NP - 1; p >= 0; p--)
        if (!m_wait[p]) begin done = 1; done_pipe = IW'(p); spur = 1; end
    end
    #1;
    slot = !m_outv || out_ready;
    pick = -1;
    for (int k = 1; k <= NP; k++) begin
      int j;
      j = (m_last + k) % NP;
      if (pick < 0 && pq[j].size() > 0 && !m_wait[j] &&
          (!m_lock || (j == m_owner && pq[j][0][0]))) pick = j;
    end
    take = slot && pick >= 0;
    exp_rdy = take ? (NP'(1) << pick) : '0;
    tag = "R2";
    if (spur) tag = "R11";
    else if (m_unl) tag = "R6";
    else if (m_lock) begin
      tag = "R4";
      for (int p = 0; p < NP; p++)
        if (p != m_owner && pq[p].size() > 0 && pq[p][0][0] && pq[p][0][3]) tag = "R5";
    end else for (int p = 0; p < NP; p++) if (m_wait[p]) tag = "R7";
    chk(tag, 32'(in_ready), 32'(exp_rdy));
    chk("R3", 32'(out_valid), 32'(m_outv));
    if (m_outv) begin
      chk("R3", 32'(out_pipe), 32'(m_opipe));
      chk("R3", 32'(out_data), 32'(m_odata));
      chk(m_oflags[0] ? "R10" : "R9", 32'(out_flags), 32'(m_oflags));
    end
    chk("R8", 32'(irq), 32'(m_irq));
    chk("R9", 32'(err), 32'(m_err));
    handoff = m_outv && out_ready;
    m_irq = (handoff && m_oflags[1]) ? (NP'(1) << m_opipe) : '0;
    if (handoff && (m_oflags[2] || m_oflags[4])) begin
      dq_pipe.push_back(m_opipe); dq_due.push_back(cyc + 3);
    end
    if (done && m_wait[done_pipe]) begin
      m_wait[done_pipe] = 0;
      if (m_unl && int'(done_pipe) == m_owner) begin m_lock = 0; m_unl = 0; end
    end
    if (take) begin
      raw = pq[pick][0][FW-1:0];
      cf = clean(raw, b);
      if (b) m_err[pick] = 1'b1;
      m_outv = 1; m_opipe = pick; m_oflags = cf; m_odata = pq[pick][0][DW+FW-1:FW];
      m_last = pick;
      pop_pend[pick] = 1;
      if (cf[3] && !m_lock) begin m_lock = 1; m_owner = pick; end
      if (cf[2] || cf[4]) m_wait[pick] = 1;
      if (cf[4] && (m_lock || cf[3])) m_unl = 1;
    end else if (handoff) m_outv = 0;
  endtask

  function automatic bit idle();
    bit r;
    r = !m_outv && !m_lock && dq_pipe.size() == 0;
    for (int p = 0; p < NP; p++) r = r && pq[p].size() == 0 && !m_wait[p];
    return r;
  endfunction

  task automatic run(input int mode, input bit sp);
    int n;
    rdy_mode = mode; spur_en = sp; n = 0;
    while (!idle() && n < 3000 && !timed_out) begin
      step(); n++;
      if (cyc > 150000) timed_out = 1;
    end
    if (!idle()) begin fails++; checks++; $display("FAIL R2 drain stalled actual=busy expected=idle"); end
    step(); step();
  endtask

  initial begin
    rst_ni = 0; in_valid = '0; in_flags = '0; in_data = '0;
    out_ready = 0; done = 0; done_pipe = '0;
    for (int p = 0; p < NP; p++) begin m_wait[p] = 0; pop_pend[p] = 0; end
    m_last = NP - 1; m_owner = 0; m_opipe = 0; m_lock = 0; m_unl = 0; m_outv = 0;
    m_oflags = '0; m_odata = '0; m_irq = '0; m_err = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    #1;
    chk("R1", 32'(out_valid), 0);
    chk("R1", 32'(irq), 0);
    chk("R1", 32'(err), 0);
    chk("R1", 32'(in_ready), 0);
    // plain rotation, output always ready
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 3; k++) pq[p].push_back(mk((k == 1) ? (C | I) : ((p % 2) ? C : 6'd0), p * 16 + k));
    run(0, 0);
    // back-pressure and notify-when-done
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 3; k++) pq[p].push_back(mk((k == 0 && p % 2 == 0) ? (C | N) : (C | I), 256 + p * 16 + k));
    run(1, 0);
    // overlapping lock series
    pq[2].push_back(mk(C | L, 1)); pq[2].push_back(mk(C, 2));
    pq[2].push_back(mk(C | N, 3)); pq[2].push_back(mk(C | U | I, 4));
    pq[4].push_back(mk(C | L, 5)); pq[4].push_back(mk(C, 6)); pq[4].push_back(mk(C | U, 7));
    pq[5].push_back(mk(C | L | U, 8));
    pq[0].push_back(mk(6'd0, 9)); pq[0].push_back(mk(I | E, 10));
    run(2, 0);
    chk("R6", 32'(err), 0);
    // misused flags and spurious completions
    pq[1].push_back(mk(L, 11)); pq[3].push_back(mk(N | U, 12));
    pq[0].push_back(mk(C | E, 13)); pq[5].push_back(mk(I, 14));
    pq[2].push_back(mk(C | N, 15)); pq[4].push_back(mk(E | I, 16));
    for (int k = 0; k < 6; k++) pq[k].push_back(mk(C, 32 + k));
    run(0, 1);
    chk("R9", 32'(err), 32'(6'b001010 | 6'b000001));
    chk("R10", 32'(err[0]), 1);
    if (timed_out) begin fails++; checks++; $display("FAIL R2 watchdog actual=hung expected=done"); end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule